// File: doc/BRIEF.md
# Capture-Compare Timer

A free-running 16-bit timer with one input-capture channel, one output-compare channel and an overflow event. The counter advances on each cycle where the tick enable input is high, so a prescaler outside the block can set the count rate. A selectable edge on the capture pin copies the counter into a capture register. A counter value equal to the compare register drives the compare pin to a programmed level. Passing from 0xFFFF to 0x0000 marks an overflow.

Each of the three events sets its own status flag. A flag feeds the single interrupt request only while its enable bit is set. Software clears a flag in two steps. First it reads the status register while the flag is set. Then it accesses the data register tied to that flag. A byte-wide register port with combinational read data gives access to the control, status, capture, compare and counter registers.

Top module: `cct_timer`

## Requirements
- R1: The control register sits at byte address 0x12 and is read/write. Bit 7 enables the capture interrupt, bit 6 the compare interrupt, bit 5 the overflow interrupt, bit 1 selects the capture edge (1 = rising, 0 = falling) and bit 0 is the compare output level. Bits 4..2 always read 0.
- R2: Reset clears the three enables, the output level bit, all flags and the counter, sets the compare register to 0xFFFF and drives the compare pin low. The capture edge select bit keeps its value through reset.
- R3: The counter (0x18 high byte, 0x19 low byte, read-only) increments by one only on cycles with tick high and wraps from 0xFFFF to 0x0000. That wrap sets the overflow flag in the same clock edge.
- R4: A capture occurs only on the pin transition selected by the edge bit. A transition of the other direction changes neither the capture register nor the capture flag.
- R5: The capture pin passes two synchronizer flops and an edge detector. The capture register (0x14 high, 0x15 low, read-only) is loaded with the counter value on the third clock edge after the pin changes, and the capture flag sets on that same edge.
- R6: When a tick moves the counter to a value equal to the compare register (0x16 high, 0x17 low, read/write), the compare flag sets and the compare pin takes the output level bit on that same edge.
- R7: Between matches the compare pin holds its last driven level, even while the output level bit changes.
- R8: The status register at 0x13 reads the capture flag in bit 7, the compare flag in bit 6 and the overflow flag in bit 5, with bits 4..0 at 0.
- R9: A flag clears only after a status read that saw it set is followed by its access: a read of 0x15 for capture, a write of 0x17 for compare, a read of 0x19 for overflow. The same access without that prior status read leaves the flag set.
- R10: The interrupt request is high exactly while at least one set flag has its enable bit at 1.
- R11: An event that arrives on the same edge as the clearing access of its flag leaves the flag set. Events of different kinds on the same edge each set their own flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable for the timer counter |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high, 0 otherwise |
| cap_pin | input | 1 | Asynchronous capture input |
| cmp_pin | output | 1 | Compare output level |
| irq | output | 1 | Combined interrupt request |

## Verification
Two same-edge collisions matter most. In the first, a synchronized capture edge and a counter tick that hits the compare value land on the same edge. The bench times the pin change three edges ahead of a single tick and then expects both status bits set and the pre-tick count in the capture register. In the second, a new capture lands on the same edge as the capture-low read that would clear the flag. The flag must survive, and the capture register must hold the new count. The compare and overflow paths are swept, with an arithmetic model checking the pin and the interrupt on every tick across a full counter wrap.

// File: rtl/cct_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the capture-compare timer.
// Assumes a byte-wide register port and a counter of two bytes.
package cct_pkg;
    localparam int BYTE_W  = 8;
    localparam int CNT_W   = 2 * BYTE_W;
    localparam int NUM_EV  = 3;

    // Event indices; index + 5 gives the bit in control and status.
    localparam int EV_OVF  = 0;
    localparam int EV_CMP  = 1;
    localparam int EV_CAP  = 2;

    // Control register bit positions.
    localparam int CTL_LVL  = 0;
    localparam int CTL_EDGE = 1;
    localparam int CTL_ENLO = 5;

    // Register byte addresses.
    localparam logic [7:0] A_CTRL = 8'h12;
    localparam logic [7:0] A_STAT = 8'h13;
    localparam logic [7:0] A_CAPH = 8'h14;
    localparam logic [7:0] A_CAPL = 8'h15;
    localparam logic [7:0] A_CMPH = 8'h16;
    localparam logic [7:0] A_CMPL = 8'h17;
    localparam logic [7:0] A_CNTH = 8'h18;
    localparam logic [7:0] A_CNTL = 8'h19;

    typedef logic [NUM_EV-1:0] ev_vec_t;
endpackage

// File: rtl/cct_counter.sv
`timescale 1ns/1ps
// Module: cct_counter
// Free-running counter with overflow and compare-match detection and
// the registered compare output pin.
// Assumes: tick is a single-cycle count enable; a match is judged on the
// value the counter takes at the edge, so flag and pin move with it.
module cct_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             out_lvl,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf_evt,
    output logic             cmp_evt,
    output logic             pin_q
);
    logic [CNT_W-1:0] cnt_nxt;

    // Next count and event detection for the current tick.
    always_comb begin
        cnt_nxt = cnt_q + CNT_W'(1);
        ovf_evt = tick && (cnt_q == {CNT_W{1'b1}});
        cmp_evt = tick && (cnt_nxt == cmp_val);
    end

    // Counter register: advances only on tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_nxt;
        end
    end

    // Compare pin: takes the output level on a match, otherwise holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
        end else if (cmp_evt) begin
            pin_q <= out_lvl;
        end
    end
endmodule

// File: rtl/cct_capture.sv
`timescale 1ns/1ps
// Module: cct_capture
// Synchronizes the capture pin, detects the selected edge and loads the
// capture register with the counter value of the detection cycle.
// Assumes: SYNC_STAGES >= 1; synchronizer flops reset to 0, so the pin
// is expected low when reset is released.
module cct_capture #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_in,
    input  logic             edge_rise,
    input  logic [CNT_W-1:0] cnt_val,
    output logic [CNT_W-1:0] cap_q,
    output logic             cap_evt
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   rise;
    logic                   fall;

    generate
        if (SYNC_STAGES == 1) begin : g_sync_one
            // Single-flop synchronizer variant.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= pin_in;
            end
        end else begin : g_sync_chain
            // Shift chain synchronizer; the top bit is the settled pin.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
            end
        end
    endgenerate

    // Previous settled level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[SYNC_STAGES-1];
    end

    // Edge detection with polarity select.
    always_comb begin
        rise    = sync_q[SYNC_STAGES-1] && !last_q;
        fall    = !sync_q[SYNC_STAGES-1] && last_q;
        cap_evt = edge_rise ? rise : fall;
    end

    // Capture register: loads the running count on a detected edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       cap_q <= '0;
        else if (cap_evt) cap_q <= cnt_val;
    end
endmodule

// File: rtl/cct_regs.sv
`timescale 1ns/1ps
// Module: cct_regs
// Register file: control, compare value, status flags with the two-step
// clear, read multiplexer and interrupt combining.
// Assumes: one-cycle bus strobes, never read and write together; a set
// event outranks a clear on the same edge.
module cct_regs
    import cct_pkg::*;
#(
    parameter int CNT_W = cct_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic [CNT_W-1:0] cap_val,
    input  ev_vec_t          evt,
    output logic [CNT_W-1:0] cmp_q,
    output logic             olvl_q,
    output logic             edge_q,
    output ev_vec_t          flag_q,
    output ev_vec_t          en_q,
    output logic             irq
);
    localparam int HI_LSB = CNT_W - BYTE_W;

    ev_vec_t arm_q;
    ev_vec_t clr_acc;
    logic    ctl_wr;
    logic    stat_rd;

    // Address decode for strobes that have side effects.
    always_comb begin
        ctl_wr           = bus_wr && (bus_addr == A_CTRL);
        stat_rd          = bus_rd && (bus_addr == A_STAT);
        clr_acc[EV_CAP]  = bus_rd && (bus_addr == A_CAPL);
        clr_acc[EV_CMP]  = bus_wr && (bus_addr == A_CMPL);
        clr_acc[EV_OVF]  = bus_rd && (bus_addr == A_CNTL);
    end

    // Control bits that reset: interrupt enables and output level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            olvl_q <= 1'b0;
        end else if (ctl_wr) begin
            en_q   <= bus_wdata[CTL_ENLO +: NUM_EV];
            olvl_q <= bus_wdata[CTL_LVL];
        end
    end

    // Edge select: deliberately untouched by reset.
    always_ff @(posedge clk) begin
        if (ctl_wr) edge_q <= bus_wdata[CTL_EDGE];
    end

    // Compare register, written one byte at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '1;
        end else if (bus_wr && (bus_addr == A_CMPH)) begin
            cmp_q[CNT_W-1:HI_LSB] <= bus_wdata;
        end else if (clr_acc[EV_CMP]) begin
            cmp_q[BYTE_W-1:0] <= bus_wdata;
        end
    end

    // Flags and clear arming: a status read arms set flags, the matching
    // access then clears; a same-edge event wins over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
            arm_q  <= '0;
        end else begin
            for (int e = 0; e < NUM_EV; e++) begin
                if (evt[e]) begin
                    flag_q[e] <= 1'b1;
                    if (clr_acc[e]) arm_q[e] <= 1'b0;
                end else if (clr_acc[e] && arm_q[e]) begin
                    flag_q[e] <= 1'b0;
                    arm_q[e]  <= 1'b0;
                end else if (stat_rd && flag_q[e]) begin
                    arm_q[e]  <= 1'b1;
                end
            end
        end
    end

    // Read multiplexer; returns 0 when no read is strobed.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                A_CTRL: bus_rdata = {en_q, 3'b000, edge_q, olvl_q};
                A_STAT: bus_rdata = {flag_q, 5'b00000};
                A_CAPH: bus_rdata = cap_val[CNT_W-1:HI_LSB];
                A_CAPL: bus_rdata = cap_val[BYTE_W-1:0];
                A_CMPH: bus_rdata = cmp_q[CNT_W-1:HI_LSB];
                A_CMPL: bus_rdata = cmp_q[BYTE_W-1:0];
                A_CNTH: bus_rdata = cnt_val[CNT_W-1:HI_LSB];
                A_CNTL: bus_rdata = cnt_val[BYTE_W-1:0];
                default: bus_rdata = '0;
            endcase
        end
    end

    // Interrupt request: any set flag with its enable.
    always_comb irq = |(flag_q & en_q);
endmodule

// File: rtl/cct_timer.sv
`timescale 1ns/1ps
// Module: cct_timer (top)
// Capture-compare timer: counter, capture channel and register file.
// Assumes: byte register port with one-cycle strobes; cap_pin is
// asynchronous and low at reset release.
module cct_timer
    import cct_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [7:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       cap_pin,
    output logic       cmp_pin,
    output logic       irq
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cap_q;
    logic [CNT_W-1:0] cmp_val;
    logic             olvl;
    logic             edge_rise;
    logic             ovf_evt;
    logic             cmp_evt;
    logic             cap_evt;
    ev_vec_t          flag_q;
    ev_vec_t          en_q;
    ev_vec_t          evt;

    // Gather the three event strobes in flag order.
    always_comb begin
        evt          = '0;
        evt[EV_OVF]  = ovf_evt;
        evt[EV_CMP]  = cmp_evt;
        evt[EV_CAP]  = cap_evt;
    end

    cct_counter #(.CNT_W(CNT_W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .cmp_val (cmp_val),
        .out_lvl (olvl),
        .cnt_q   (cnt_q),
        .ovf_evt (ovf_evt),
        .cmp_evt (cmp_evt),
        .pin_q   (cmp_pin)
    );

    cct_capture #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (cap_pin),
        .edge_rise (edge_rise),
        .cnt_val   (cnt_q),
        .cap_q     (cap_q),
        .cap_evt   (cap_evt)
    );

    cct_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_val   (cnt_q),
        .cap_val   (cap_q),
        .evt       (evt),
        .cmp_q     (cmp_val),
        .olvl_q    (olvl),
        .edge_q    (edge_rise),
        .flag_q    (flag_q),
        .en_q      (en_q),
        .irq       (irq)
    );
endmodule

// File: rtl/cct_timer_chk.sv
`timescale 1ns/1ps
// Module: cct_timer_chk
// Assertion checker bound to cct_timer; observes ports and the state
// passed between its sub-blocks.
module cct_timer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic        bus_rd,
    input logic [7:0]  bus_addr,
    input logic [7:0]  bus_rdata,
    input logic        cmp_pin,
    input logic        irq,
    input logic [15:0] cnt_q,
    input logic [15:0] cmp_val,
    input logic        olvl,
    input logic [2:0]  flag_q
);
    // R1: unimplemented control bits read zero.
    p_unimpl_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 8'h12) |-> (bus_rdata[4:2] == 3'b000));

    // R3: no tick, no count change.
    p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q));

    // R3: a tick advances by exactly one, modulo the width.
    p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == $past(cnt_q) + 16'd1));

    // R3: a tick at all-ones leaves the overflow flag set.
    p_wrap_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q == 16'hFFFF) |=> flag_q[0]);

    // R6: a tick landing on the compare value drives the pin to the level.
    p_pin_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (cnt_q + 16'd1) == cmp_val) |=> (cmp_pin == $past(olvl) && flag_q[1]));

    // R7: without a match the pin holds.
    p_pin_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && (cnt_q + 16'd1) == cmp_val) |=> $stable(cmp_pin));

    // R10: an interrupt needs at least one flag.
    p_irq_has_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag_q != 3'b000));
endmodule

bind cct_timer cct_timer_chk u_cct_timer_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .cmp_pin   (cmp_pin),
    .irq       (irq),
    .cnt_q     (cnt_q),
    .cmp_val   (cmp_val),
    .olvl      (olvl),
    .flag_q    (flag_q)
);

// File: tb/cct_timer_bench.sv
`timescale 1ns/1ps
// Bench for cct_timer: arithmetic model of counter, flags and pin,
// swept over compare targets, capture polarities and a full wrap.
module cct_timer_bench;
    localparam logic [7:0] A_CTRL = 8'h12, A_STAT = 8'h13, A_CAPH = 8'h14,
                           A_CAPL = 8'h15, A_CMPH = 8'h16, A_CMPL = 8'h17,
                           A_CNTH = 8'h18, A_CNTL = 8'h19;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       cap_pin = 1'b0;
    logic       cmp_pin;
    logic       irq;

    int nvec = 0;
    int nfail = 0;

    // Model state.
    logic [15:0] m_cnt = 16'h0000, m_cmp = 16'hFFFF, m_cap = 16'h0000;
    logic [2:0]  m_flag = 3'b000, m_arm = 3'b000, m_en = 3'b000;
    logic        m_olvl = 1'b0, m_edge = 1'b0, m_pin = 1'b0;

    always #2.5 clk = ~clk;

    cct_timer u_cct_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cap_pin(cap_pin), .cmp_pin(cmp_pin), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        case (a)
            A_CTRL: begin m_en = d[7:5]; m_edge = d[1]; m_olvl = d[0]; end
            A_CMPH: m_cmp[15:8] = d;
            A_CMPL: begin
                m_cmp[7:0] = d;
                if (m_arm[1]) begin m_flag[1] = 1'b0; m_arm[1] = 1'b0; end
            end
            default: ;
        endcase
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
        case (a)
            A_STAT: m_arm = m_arm | m_flag;
            A_CAPL: if (m_arm[2]) begin m_flag[2] = 1'b0; m_arm[2] = 1'b0; end
            A_CNTL: if (m_arm[0]) begin m_flag[0] = 1'b0; m_arm[0] = 1'b0; end
            default: ;
        endcase
    endtask

    task automatic chk_pins(input string req);
        chk({req, " R7 pin"}, int'(cmp_pin), int'(m_pin));
        chk({req, " R10 irq"}, int'(irq), int'(|(m_flag & m_en)));
    endtask

    // Apply n ticks; check pin and irq after every one.
    task automatic tick_watch(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i > 0) chk_pins(req);
            tick = 1'b1;
            @(posedge clk); #1;
            if (m_cnt == 16'hFFFF) m_flag[0] = 1'b1;
            m_cnt = m_cnt + 16'd1;
            if (m_cnt == m_cmp) begin m_flag[1] = 1'b1; m_pin = m_olvl; end
        end
        @(negedge clk);
        tick = 1'b0;
        chk_pins(req);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_cnt = 16'h0000; m_cmp = 16'hFFFF; m_cap = 16'h0000;
        m_flag = 3'b000; m_arm = 3'b000; m_en = 3'b000;
        m_olvl = 1'b0; m_pin = 1'b0;
    endtask

    task automatic chk_status(input string req);
        logic [7:0] d;
        bus_read(A_STAT, d);
        chk({req, " R8 status"}, int'(d), int'({m_flag_pre, 5'b0}));
    endtask
    logic [2:0] m_flag_pre;

    task automatic read_cap(input string req);
        logic [7:0] h, l;
        bus_read(A_CAPH, h);
        bus_read(A_CAPL, l);
        chk({req, " R5 capture"}, int'({h, l}), int'(m_cap));
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin : main
        logic [7:0] d, h;
        logic [15:0] tgt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state.
        bus_read(A_CTRL, d); chk("R2 ctrl reset", int'(d & 8'hFD), 0);
        m_flag_pre = m_flag; chk_status("R2");
        bus_read(A_CMPH, h); bus_read(A_CMPL, d);
        chk("R2 compare reset", int'({h, d}), 16'hFFFF);
        bus_read(A_CNTH, h); bus_read(A_CNTL, d);
        chk("R2 counter reset", int'({h, d}), 0);
        chk_pins("R2");

        // R1: control layout and unimplemented bits.
        bus_write(A_CTRL, 8'hFF); bus_read(A_CTRL, d); chk("R1 ctrl all-ones", int'(d), 8'hE3);
        bus_write(A_CTRL, 8'h21); bus_read(A_CTRL, d); chk("R1 ctrl pattern", int'(d), 8'h21);
        bus_write(A_CTRL, 8'h00); bus_read(A_CTRL, d); chk("R1 ctrl zero", int'(d), 8'h00);

        // R2: edge select survives reset, other bits clear.
        bus_write(A_CTRL, 8'hE3); do_reset();
        bus_read(A_CTRL, d); chk("R2 edge kept set", int'(d), 8'h02);
        bus_write(A_CTRL, 8'hC0); do_reset();
        bus_read(A_CTRL, d); chk("R2 edge kept clear", int'(d), 8'h00);
        chk_pins("R2 after reset");

        // R3: counting only on tick.
        tick_watch(300, "R3 count");
        repeat (5) @(negedge clk);
        bus_read(A_CNTH, h); bus_read(A_CNTL, d);
        chk("R3 counter value", int'({h, d}), int'(m_cnt));

        // R6/R7/R9: compare sweep with alternating output level.
        for (int i = 0; i < 12; i++) begin
            tgt = m_cnt + 16'(3 + 7 * i);
            bus_write(A_CTRL, 8'h40 | 8'(i % 2));
            bus_write(A_CMPH, tgt[15:8]);
            m_flag_pre = m_flag; chk_status("R9 sweep");
            bus_write(A_CMPL, tgt[7:0]);
            chk_pins("R9 compare cleared");
            tick_watch(10 + 7 * i, "R6 sweep");
        end

        // R9: clearing access without a status read leaves the flag.
        bus_write(A_CMPL, m_cmp[7:0]);
        @(negedge clk); chk("R9 no-arm keeps irq", int'(irq), 1);
        m_flag_pre = m_flag; chk_status("R9 arm");
        bus_write(A_CMPL, m_cmp[7:0]);
        @(negedge clk); chk("R9 armed clear", int'(irq), 0);

        // R4/R5: capture polarity sweep.
        for (int j = 0; j < 8; j++) begin
            logic nl;
            bus_write(A_CTRL, {3'b100, 3'b000, 1'(j / 2 % 2), m_olvl});
            tick_watch(5 + j, "R5 move");
            nl = ~cap_pin;
            @(negedge clk) cap_pin = nl;
            repeat (5) @(posedge clk);
            if (nl == m_edge) begin m_flag[2] = 1'b1; m_cap = m_cnt; end
            @(negedge clk); chk_pins("R4 capture irq");
            m_flag_pre = m_flag; chk_status("R4 capture");
            read_cap("R4");
            @(negedge clk); chk_pins("R9 capture cleared");
        end

        // R3/R10: full wrap with overflow interrupt enabled.
        bus_write(A_CTRL, 8'h20);
        tick_watch(65536 - int'(m_cnt) + 2, "R3 wrap");
        m_flag_pre = m_flag; chk_status("R3 overflow");
        bus_read(A_CNTH, h); bus_read(A_CNTL, d);
        chk("R3 counter after wrap", int'({h, d}), int'(m_cnt));
        @(negedge clk); chk("R9 overflow cleared", int'(irq), 0);

        // R11: capture and compare on the same edge.
        m_flag_pre = m_flag; chk_status("R11 pre");
        tgt = m_cnt + 16'd1;
        bus_write(A_CMPH, tgt[15:8]); bus_write(A_CMPL, tgt[7:0]);
        bus_write(A_CTRL, 8'h22);
        @(negedge clk) cap_pin = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk) tick = 1'b1;
        @(posedge clk); #1;
        m_cap = m_cnt; m_cnt = m_cnt + 16'd1;
        m_flag[2] = 1'b1; m_flag[1] = 1'b1; m_pin = m_olvl;
        @(negedge clk) tick = 1'b0;
        m_flag_pre = m_flag; chk_status("R11 both flags");
        chk("R11 both flag bits", int'(m_flag_pre[2:1]), 3);
        bus_read(A_CAPH, h); chk("R11 capture high", int'(h), int'(m_cap[15:8]));

        // R11: new capture on the clearing read keeps the flag.
        bus_write(A_CTRL, 8'h20);
        m_flag_pre = m_flag; chk_status("R11 arm");
        @(negedge clk) cap_pin = 1'b0;
        @(posedge clk); @(posedge clk);
        bus_read(A_CAPL, d);
        m_flag[2] = 1'b1; m_arm[2] = 1'b0; m_cap = m_cnt;
        m_flag_pre = m_flag; chk_status("R11 set wins");
        read_cap("R11");
        m_flag_pre = m_flag; chk_status("R11 final");

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule